// File: doc/BRIEF.md
# Segmented DAC Leapfrog Decoder

This block is the digital front end of a segmented 16-bit voltage DAC. The analog core has a resistor string of 16 equal segments, with tap nodes numbered 0 to 16. Two 4-bit node selectors pick taps from that string, and a 12-bit interpolating sub-DAC fills in the space between the two selected taps. The decoder turns an input code into four values. Two are the tap indices for the two selectors. The third is the code for the sub-DAC. The fourth is a flag that shows when the sub-DAC inputs are reversed.

The upper bits of the code pick a segment. The two selectors always land on the two nodes that bound that segment. They leapfrog as the code rises: at a segment boundary, the selector on the shared node stays where it is. The other selector jumps past it to the far end of the new segment. Because of this, the sub-DAC sees its inputs reversed on every other segment. The decoder corrects for that by complementing the sub-DAC code on those segments, so the interpolation always runs upward.

A strobe captures the input code. All outputs update on the next clock edge, and a valid pulse marks that update. The analog string, the multiplexers and the amplifiers are outside this block.

Top module: `leap_dac_decoder`

## Requirements
- R1: The segment index is the top 4 bits of the input code, bits [15:12]. On an even segment s, the first tap output is s and the second tap output is s+1.
- R2: On an odd segment s, the first tap output is s+1 and the second tap output is s.
- R3: The sub-DAC code equals input bits [11:0] on even segments. On odd segments it equals the bitwise inverse of those bits.
- R4: The swap flag equals input bit 12. It is 1 exactly when the first tap output is above the second tap output.
- R5: The two tap outputs always differ by exactly one node, and neither one exceeds 16.
- R6: When `in_valid` is high at a clock edge, the outputs take the decoded value of `in_code` at that edge. `out_valid` is high during the following cycle, and low after any edge where `in_valid` was low.
- R7: An edge with `in_valid` low has no effect on the tap, sub-DAC and swap outputs. They keep their previous values.
- R8: After reset, the outputs are `out_valid`=0, first tap=0, second tap=1, sub-DAC code=0 and swap=0.
- R9: The output is rebuilt in units of one sub-DAC step. The lower tap times 4096 is added to the interpolation fraction. The fraction is the sub-DAC code on even segments and 4095 minus the sub-DAC code on odd segments. Across every consecutive pair of codes, this value rises by exactly 1.
- R10: Between consecutive codes, no selector moves by more than two nodes. Across a segment boundary, exactly one selector keeps its tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that captures `in_code` |
| in_code | input | 16 | DAC input code |
| out_valid | output | 1 | High during the cycle after a strobe |
| tap_first | output | 5 | Node index for the first selector (0 to 16) |
| tap_second | output | 5 | Node index for the second selector (0 to 16) |
| sub_code | output | 12 | Code for the interpolating sub-DAC |
| swapped | output | 1 | 1 when the sub-DAC inputs are reversed |

## Verification
The bound checker tests four things on every cycle. It checks that the taps are adjacent and stay in range, and that the swap flag agrees with the tap order. It also checks the one-cycle latency and valid pulse, and the hold on idle edges. Finally, it checks that the lower tap and the sub-DAC code match the code captured on the previous edge.

Some properties cannot be checked from a single cycle and need the bench's scenarios. A full ascending sweep of all 65536 codes shows that the rebuilt output rises by one step per code. The same sweep shows that the selectors leapfrog at every boundary. The bench also covers the reset state and sparse strobes with idle gaps.

// File: rtl/leap_dac_pkg.sv
package leap_dac_pkg;

  // Tap taken by the first selector for a segment index.
  function automatic int unsigned first_tap_of(input int unsigned seg);
    return (seg % 2 == 1) ? seg + 1 : seg;
  endfunction

  // Tap taken by the second selector for a segment index.
  function automatic int unsigned second_tap_of(input int unsigned seg);
    return (seg % 2 == 1) ? seg : seg + 1;
  endfunction

  // Reset image of the packed output bundle {first, second, sub, swap}.
  function automatic logic [63:0] reset_image(input int unsigned tap_w,
                                              input int unsigned sub_w);
    logic [63:0] img;
    img = '0;
    // second tap = 1, lies above sub code and swap bit
    img = 64'(64'd1 << (sub_w + 1));
    if (tap_w == 0) img = '0;
    return img;
  endfunction

endpackage

// File: rtl/leap_tap_select.sv
module leap_tap_select #(
  parameter int SEG_W = 4,
  localparam int TAP_W = SEG_W + 1
) (
  input  logic [SEG_W-1:0] seg,
  output logic [TAP_W-1:0] tap_first,
  output logic [TAP_W-1:0] tap_second,
  output logic             seg_odd
);
  import leap_dac_pkg::*;

  always_comb begin
    tap_first  = TAP_W'(first_tap_of(int'(seg)));
    tap_second = TAP_W'(second_tap_of(int'(seg)));
    seg_odd    = seg[0];
  end

endmodule

// File: rtl/leap_sub_map.sv
module leap_sub_map #(
  parameter int SUB_W = 12
) (
  input  logic [SUB_W-1:0] raw_low,
  input  logic             invert,
  output logic [SUB_W-1:0] sub_code
);

  for (genvar b = 0; b < SUB_W; b++) begin : g_bit
    assign sub_code[b] = raw_low[b] ^ invert;
  end

endmodule

// File: rtl/leap_hold_reg.sv
module leap_hold_reg #(
  parameter int          W       = 8,
  parameter logic [63:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL[W-1:0];
    else if (load) q <= d;
  end

endmodule

// File: rtl/leap_dac_decoder.sv
module leap_dac_decoder #(
  parameter int CODE_W = 16,
  parameter int SEG_W  = 4,
  localparam int SUB_W = CODE_W - SEG_W,
  localparam int TAP_W = SEG_W + 1,
  localparam int BUN_W = 2 * TAP_W + SUB_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic [TAP_W-1:0]  tap_first,
  output logic [TAP_W-1:0]  tap_second,
  output logic [SUB_W-1:0]  sub_code,
  output logic              swapped
);
  import leap_dac_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [SEG_W-1:0] seg_idx;
  logic [SUB_W-1:0] raw_low;
  logic             seg_odd;
  logic [TAP_W-1:0] tap_first_nxt;
  logic [TAP_W-1:0] tap_second_nxt;
  logic [SUB_W-1:0] sub_nxt;
  logic             load_evt;
  logic [BUN_W-1:0] bundle_nxt;
  logic [BUN_W-1:0] bundle_q;

  assign seg_idx  = in_code[CODE_W-1 -: SEG_W];
  assign raw_low  = in_code[SUB_W-1:0];
  assign load_evt = in_valid;

  leap_tap_select #(.SEG_W(SEG_W)) u_tap (
    .seg        (seg_idx),
    .tap_first  (tap_first_nxt),
    .tap_second (tap_second_nxt),
    .seg_odd    (seg_odd)
  );

  leap_sub_map #(.SUB_W(SUB_W)) u_sub (
    .raw_low  (raw_low),
    .invert   (seg_odd),
    .sub_code (sub_nxt)
  );

  assign bundle_nxt = {tap_first_nxt, tap_second_nxt, sub_nxt, seg_odd};

  leap_hold_reg #(
    .W       (BUN_W),
    .RST_VAL (reset_image(TAP_W, SUB_W))
  ) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .d     (bundle_nxt),
    .q     (bundle_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= load_evt;
  end

  assign {tap_first, tap_second, sub_code, swapped} = bundle_q;

endmodule

// File: rtl/leap_dac_decoder_chk.sv
module leap_dac_decoder_chk #(
  parameter int CODE_W = 16,
  parameter int SEG_W  = 4,
  localparam int SUB_W = CODE_W - SEG_W,
  localparam int TAP_W = SEG_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [CODE_W-1:0] in_code,
  input logic              out_valid,
  input logic [TAP_W-1:0]  tap_first,
  input logic [TAP_W-1:0]  tap_second,
  input logic [SUB_W-1:0]  sub_code,
  input logic              swapped
);
  localparam logic [TAP_W-1:0] TOP_NODE = TAP_W'(1 << SEG_W);

  logic [TAP_W-1:0] tap_low;
  logic             taps_adjacent;
  assign tap_low = (tap_first < tap_second) ? tap_first : tap_second;
  assign taps_adjacent = (tap_first == tap_second + 1'b1) ||
                         (tap_second == tap_first + 1'b1);

  assert_taps_adjacent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    taps_adjacent && tap_first <= TOP_NODE && tap_second <= TOP_NODE);

  assert_swap_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    swapped == (tap_first > tap_second));

  assert_valid_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_no_valid_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(tap_first) && $stable(tap_second) &&
                   $stable(sub_code) && $stable(swapped)));

  // R1 and R2: lower tap follows the captured segment
  assert_lower_tap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> tap_low == {1'b0, $past(in_code[CODE_W-1 -: SEG_W])});

  assert_sub_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> sub_code == ($past(in_code[SUB_W]) ? ~$past(in_code[SUB_W-1:0])
                                                    : $past(in_code[SUB_W-1:0])));

endmodule

bind leap_dac_decoder leap_dac_decoder_chk #(
  .CODE_W (CODE_W),
  .SEG_W  (SEG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_code    (in_code),
  .out_valid  (out_valid),
  .tap_first  (tap_first),
  .tap_second (tap_second),
  .sub_code   (sub_code),
  .swapped    (swapped)
);

// File: tb/leap_dac_decoder_bench.sv
module leap_dac_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_code = '0;
  logic        out_valid;
  logic [4:0]  tap_first;
  logic [4:0]  tap_second;
  logic [11:0] sub_code;
  logic        swapped;

  int checks = 0;
  int errors = 0;

  // Reference model state
  int exp_first = 0, exp_second = 1, exp_sub = 0, exp_swap = 0, exp_valid = 0;
  // Sweep tracking
  bit sweep_on = 0;
  bit have_prev = 0;
  int prev_level = 0, prev_first = 0, prev_second = 0, prev_seg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  leap_dac_decoder u_leap_dac_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .out_valid(out_valid), .tap_first(tap_first), .tap_second(tap_second),
    .sub_code(sub_code), .swapped(swapped)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_update(input bit v, input int code);
    int seg, low;
    exp_valid = v;
    if (v) begin
      seg = code / 4096;
      low = code % 4096;
      if (seg % 2 == 0) begin
        exp_first = seg; exp_second = seg + 1; exp_sub = low; exp_swap = 0;
      end else begin
        exp_first = seg + 1; exp_second = seg; exp_sub = 4095 - low; exp_swap = 1;
      end
    end
  endtask

  task automatic compare_outputs();
    check(out_valid == exp_valid, "R6 out_valid", out_valid, exp_valid);
    check(tap_first == exp_first, "R1/R2 tap_first", tap_first, exp_first);
    check(tap_second == exp_second, "R1/R2 tap_second", tap_second, exp_second);
    check(sub_code == exp_sub, "R3 sub_code", sub_code, exp_sub);
    check(swapped == exp_swap, "R4 swapped", swapped, exp_swap);
  endtask

  task automatic sweep_checks();
    int lo, frac, level, seg;
    if (!(sweep_on && out_valid)) return;
    lo = (tap_first < tap_second) ? tap_first : tap_second;
    frac = swapped ? 4095 - sub_code : sub_code;
    level = lo * 4096 + frac;
    seg = lo;
    check((tap_first > tap_second ? tap_first - tap_second : tap_second - tap_first) == 1,
          "R5 adjacency", tap_first, tap_second);
    if (have_prev) begin
      check(level == prev_level + 1, "R9 monotonic step", level, prev_level + 1);
      check(int'(tap_first) - prev_first <= 2 && prev_first - int'(tap_first) <= 2,
            "R10 first move", tap_first, prev_first);
      check(int'(tap_second) - prev_second <= 2 && prev_second - int'(tap_second) <= 2,
            "R10 second move", tap_second, prev_second);
      if (seg != prev_seg)
        check((tap_first == prev_first) != (tap_second == prev_second),
              "R10 one selector stays", tap_first, prev_first);
    end
    have_prev = 1;
    prev_level = level; prev_first = tap_first; prev_second = tap_second; prev_seg = seg;
  endtask

  // One cycle: check outputs of previous drive, then drive new inputs.
  task automatic step(input bit v, input int code);
    @(negedge clk);
    compare_outputs();
    sweep_checks();
    in_valid = v;
    in_code  = 16'(code);
    model_update(v, code);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(out_valid == 0, "R8 reset out_valid", out_valid, 0);
    check(tap_first == 0, "R8 reset tap_first", tap_first, 0);
    check(tap_second == 1, "R8 reset tap_second", tap_second, 1);
    check(sub_code == 0, "R8 reset sub_code", sub_code, 0);
    check(swapped == 0, "R8 reset swapped", swapped, 0);
    rst_n = 1'b1;

    // Sparse strobes with idle gaps (R7 hold)
    step(1, 16'h1abc);
    step(0, 16'h0000);
    step(0, 16'hffff);
    step(1, 16'hf000);
    step(0, 16'h2345);
    step(1, 16'h0fff);
    step(1, 16'hffff);
    step(0, 16'h8000);
    step(1, 16'h8001);
    step(0, 16'h0);

    // Full ascending sweep (R9, R10)
    sweep_on = 1;
    for (int c = 0; c < 65536; c++) step(1, c);
    step(0, 0);
    sweep_on = 0;
    step(0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule